// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block runs one conversion on an external four-channel converter. A client hands it a 2-bit channel number over a valid/ready request channel. The block then writes a byte-wide control register in the order the converter needs: bias, then enable, then channel, then start. It waits the required settling delays between those writes and then waits for a conversion-done pulse, with a timeout. On success it reads the two-byte result word for the channel and returns the low 10 bits over a valid/ready response channel, together with a status code.

Every run ends with a teardown, whatever its outcome. The block writes the control register again to drop start and enable, and, for the thermistor channel, drops the bias in one more write. Only then does it present the response. All delays are held as microsecond parameters and turned into clock cycles from a clock-frequency parameter.

Back-pressure works like this. A request transfers only on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the block is idle, so it stays low from acceptance until the response has been taken. A response stays presented, with unchanged data and status, until a cycle where `rsp_ready` is high.

Top module: `adc_seq_top`

## Requirements
- R1: `req_ready` is high only while idle. A request offered during a conversion, or while a response is pending, is not accepted and starts no control writes.
- R2: All control writes go to address 0x50. The control bits are: start at bit 0, channel at bits 2:1, enable at bit 5, bias at bit 6. Enable is set in a write that leaves start clear. The next write loads the channel field. The write after that sets start.
- R3: The start write comes exactly GAP_US microseconds' worth of cycles after the enable write.
- R4: For channel 2 only, a first write sets the bias bit, and the enable write follows BIAS_US microseconds' worth of cycles later. For the other channels the bias bit is never set.
- R5: A conversion-done pulse seen before a request is accepted has no effect on that conversion. Without a fresh pulse the conversion ends in a timeout.
- R6: If no done pulse arrives, the run ends with status 1 (timeout) and makes no result reads. Its teardown write comes TIMEOUT_US microseconds' worth of cycles plus one after the start write.
- R7: After a done pulse, the block reads address 0x54+2·n and then 0x55+2·n, each read held until acknowledged. It returns the first byte as the upper bits and keeps only the low 10 bits, with status 0.
- R8: A read acknowledged with `rd_err` ends the run with status 2, and no further read is issued.
- R9: Before the response is presented, a write clears start and enable while keeping the channel field. For channel 2 a further write then clears bias. This holds on success, timeout and read error alike.
- R10: A presented response keeps `rsp_valid`, `rsp_data` and `rsp_err` unchanged until `rsp_ready` is high.
- R11: During and after reset `req_ready` is high, `rsp_valid` is low, no write or read is requested, and the shadow control value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | block idle, request can transfer |
| req_chan | input | 2 | channel to convert |
| rsp_valid | output | 1 | response presented |
| rsp_ready | input | 1 | client takes response |
| rsp_data | output | DATA_W | conversion result (0 on error) |
| rsp_err | output | 2 | 0 ok, 1 timeout, 2 read error |
| ctrl_wr_en | output | 1 | control register write strobe |
| ctrl_wr_addr | output | 8 | control register address |
| ctrl_wr_data | output | 8 | full new control register value |
| rd_req | output | 1 | result byte read request |
| rd_addr | output | 8 | result byte address |
| rd_ack | input | 1 | read completed this cycle |
| rd_data | input | 8 | read byte, valid with rd_ack |
| rd_err | input | 1 | read failed, valid with rd_ack |
| conv_done | input | 1 | conversion-done pulse |

## Verification
The hardest case to reach from the ports is a done pulse that belongs to no conversion. The bench fires that pulse while the block is idle, then issues a request and never answers its start write, so only a correct clear of the done latch at acceptance turns the run into a timeout. A second hard case is a read error on the second byte of the thermistor channel. There the teardown must still clear the bias in its own extra write, which the bench reaches by failing the second acknowledge while logging every control write with its cycle stamp.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_W   = 8;
  localparam int B_GO     = 0;
  localparam int B_CH_LO  = 1;
  localparam int B_CH_HI  = 2;
  localparam int B_EN     = 5;
  localparam int B_BIAS   = 6;
  localparam logic [1:0] THERM_CH = 2'd2;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_RDERR   = 2'd2
  } status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_BIAS_ON, S_BIAS_WAIT, S_EN_ON, S_CH_SEL, S_GAP_WAIT,
    S_START_ON, S_CONV_WAIT, S_READ, S_TD_RUN, S_TD_BIAS, S_RESP
  } seq_state_e;

  function automatic longint us_to_cyc(longint khz, longint us);
    return (khz * us + 999) / 1000;
  endfunction

  function automatic longint max3(longint a, longint b, longint c);
    longint m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= W'(1);
    else if (cnt_q != '1)      cnt_q <= cnt_q + W'(1);
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/adc_seq_rdcap.sv
module adc_seq_rdcap #(
  parameter int         DATA_W = 10,
  parameter logic [7:0] BASE   = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        chan,
  output logic              rd_req,
  output logic [7:0]        rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  input  logic              rd_err,
  output logic              fin,
  output logic              fin_err,
  output logic [DATA_W-1:0] word
);
  typedef enum logic [1:0] {RC_IDLE, RC_HI, RC_LO} rc_e;
  rc_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= RC_IDLE;
    else begin
      case (phase_q)
        RC_IDLE: if (go) phase_q <= RC_HI;
        RC_HI:   if (rd_ack) phase_q <= rd_err ? RC_IDLE : RC_LO;
        RC_LO:   if (rd_ack) phase_q <= RC_IDLE;
        default: phase_q <= RC_IDLE;
      endcase
    end
  end

  assign rd_req  = (phase_q != RC_IDLE);
  assign rd_addr = BASE + {5'b0, chan, 1'b0} + {7'b0, (phase_q == RC_LO)};
  assign fin     = rd_ack && ((phase_q == RC_HI && rd_err) || phase_q == RC_LO);
  assign fin_err = rd_err;

  generate
    if (DATA_W > 8) begin : g_two_byte
      localparam int HI_W = DATA_W - 8;
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else if (phase_q == RC_HI && rd_ack && !rd_err) hi_q <= rd_data[HI_W-1:0];
      end
      assign word = {hi_q, rd_data};
    end else begin : g_one_byte
      assign word = rd_data[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int     DATA_W = 10,
  parameter int     W      = 8,
  parameter longint BIAS_C = 4,
  parameter longint GAP_C  = 4,
  parameter longint TO_C   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [1:0]        req_chan,
  input  logic              done_seen,
  input  logic              t_hit,
  output logic              t_load,
  output logic [W-1:0]      t_limit,
  output logic              rd_go,
  input  logic              rd_fin,
  input  logic              rd_fail,
  input  logic [DATA_W-1:0] rd_word,
  output logic [1:0]        chan,
  output logic              ctrl_wr,
  output logic [CTRL_W-1:0] ctrl_data,
  output logic              idle,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_err
);
  localparam logic [W-1:0] LIM_BIAS = W'(BIAS_C - 1);
  localparam logic [W-1:0] LIM_GAP  = W'(GAP_C - 1);
  localparam logic [W-1:0] LIM_TO   = W'(TO_C);

  seq_state_e          st_q, st_d;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [1:0]          chan_q;
  status_e             stat_q;
  logic [DATA_W-1:0]   res_q;

  always_comb begin
    st_d      = st_q;
    t_load    = 1'b0;
    t_limit   = '0;
    ctrl_wr   = 1'b0;
    ctrl_data = ctrl_q;
    rd_go     = 1'b0;
    case (st_q)
      S_IDLE:      if (req_fire) st_d = (req_chan == THERM_CH) ? S_BIAS_ON : S_EN_ON;
      S_BIAS_ON: begin
        ctrl_wr = 1'b1; ctrl_data[B_BIAS] = 1'b1; t_load = 1'b1; st_d = S_BIAS_WAIT;
      end
      S_BIAS_WAIT: begin
        t_limit = LIM_BIAS;
        if (t_hit) st_d = S_EN_ON;
      end
      S_EN_ON: begin
        ctrl_wr = 1'b1; ctrl_data[B_EN] = 1'b1; t_load = 1'b1; st_d = S_CH_SEL;
      end
      S_CH_SEL: begin
        ctrl_wr = 1'b1; ctrl_data[B_CH_HI:B_CH_LO] = chan_q; st_d = S_GAP_WAIT;
      end
      S_GAP_WAIT: begin
        t_limit = LIM_GAP;
        if (t_hit) st_d = S_START_ON;
      end
      S_START_ON: begin
        ctrl_wr = 1'b1; ctrl_data[B_GO] = 1'b1; t_load = 1'b1; st_d = S_CONV_WAIT;
      end
      S_CONV_WAIT: begin
        t_limit = LIM_TO;
        if (done_seen) begin
          rd_go = 1'b1; st_d = S_READ;
        end else if (t_hit) begin
          st_d = S_TD_RUN;
        end
      end
      S_READ:      if (rd_fin) st_d = S_TD_RUN;
      S_TD_RUN: begin
        ctrl_wr = 1'b1; ctrl_data[B_GO] = 1'b0; ctrl_data[B_EN] = 1'b0;
        st_d = ctrl_q[B_BIAS] ? S_TD_BIAS : S_RESP;
      end
      S_TD_BIAS: begin
        ctrl_wr = 1'b1; ctrl_data[B_BIAS] = 1'b0; st_d = S_RESP;
      end
      S_RESP:      if (rsp_ready) st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ctrl_q <= '0;
      chan_q <= '0;
      stat_q <= ST_OK;
      res_q  <= '0;
    end else begin
      st_q <= st_d;
      if (ctrl_wr) ctrl_q <= ctrl_data;
      if (st_q == S_IDLE && req_fire) begin
        chan_q <= req_chan;
        stat_q <= ST_OK;
        res_q  <= '0;
      end
      if (st_q == S_CONV_WAIT && !done_seen && t_hit) stat_q <= ST_TIMEOUT;
      if (st_q == S_READ && rd_fin) begin
        if (rd_fail) stat_q <= ST_RDERR;
        else         res_q  <= rd_word;
      end
    end
  end

  assign chan      = chan_q;
  assign idle      = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RESP);
  assign rsp_data  = res_q;
  assign rsp_err   = stat_q;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter longint     CLK_KHZ    = 125000,
  parameter longint     GAP_US     = 50,
  parameter longint     BIAS_US    = 35000,
  parameter longint     TIMEOUT_US = 5000000,
  parameter int         DATA_W     = 10,
  parameter logic [7:0] CTRL_ADDR  = 8'h50,
  parameter logic [7:0] DATA_BASE  = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_chan,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_err,
  output logic              ctrl_wr_en,
  output logic [7:0]        ctrl_wr_addr,
  output logic [7:0]        ctrl_wr_data,
  output logic              rd_req,
  output logic [7:0]        rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  input  logic              rd_err,
  input  logic              conv_done
);
  localparam longint GAP_CYC  = us_to_cyc(CLK_KHZ, GAP_US);
  localparam longint BIAS_CYC = us_to_cyc(CLK_KHZ, BIAS_US);
  localparam longint TO_CYC   = us_to_cyc(CLK_KHZ, TIMEOUT_US);
  localparam int     CNT_W    = $clog2(max3(GAP_CYC, BIAS_CYC, TO_CYC) + 2);

  logic              req_fire, idle;
  logic              done_q;
  logic              t_load, t_hit;
  logic [CNT_W-1:0]  t_limit;
  logic              rd_go, rd_fin, rd_fail;
  logic [DATA_W-1:0] rd_word;
  logic [1:0]        chan;

  assign req_ready    = idle;
  assign req_fire     = req_valid && idle;
  assign ctrl_wr_addr = CTRL_ADDR;

  // done latch: cleared when a request is taken, so stale pulses are dropped
  always_ff @(posedge clk) begin
    if (!rst_n)         done_q <= 1'b0;
    else if (req_fire)  done_q <= 1'b0;
    else if (conv_done) done_q <= 1'b1;
  end

  adc_seq_timer #(.W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .limit(t_limit), .hit(t_hit)
  );

  adc_seq_rdcap #(.DATA_W(DATA_W), .BASE(DATA_BASE)) rdc_i (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .chan(chan),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .fin(rd_fin), .fin_err(rd_fail), .word(rd_word)
  );

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .W(CNT_W), .BIAS_C(BIAS_CYC), .GAP_C(GAP_CYC), .TO_C(TO_CYC)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_chan(req_chan),
    .done_seen(done_q), .t_hit(t_hit), .t_load(t_load), .t_limit(t_limit),
    .rd_go(rd_go), .rd_fin(rd_fin), .rd_fail(rd_fail), .rd_word(rd_word),
    .chan(chan), .ctrl_wr(ctrl_wr_en), .ctrl_data(ctrl_wr_data), .idle(idle),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter longint GAP_CYC = 4,
  parameter int     DATA_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_err,
  input logic              ctrl_wr_en,
  input logic [7:0]        ctrl_wr_data,
  input logic              rd_req,
  input logic [7:0]        rd_addr,
  input logic              rd_ack
);
  logic [7:0]  last_q;
  logic [31:0] since_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= '0;
      since_en_q <= '0;
    end else begin
      if (ctrl_wr_en) last_q <= ctrl_wr_data;
      if (ctrl_wr_en && ctrl_wr_data[5] && !last_q[5]) since_en_q <= 32'd1;
      else if (since_en_q != '1) since_en_q <= since_en_q + 32'd1;
    end
  end

  a_r2_en_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && ctrl_wr_data[5] && !last_q[5] |-> !ctrl_wr_data[0]);
  a_r2_start_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && ctrl_wr_data[0] |-> last_q[5]);
  a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && ctrl_wr_data[0] && !last_q[0] |-> since_en_q >= 32'(GAP_CYC));
  a_r4_bias_therm: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && ctrl_wr_data[0] && ctrl_wr_data[2:1] == 2'd2 |-> ctrl_wr_data[6]);
  a_r4_no_bias_other: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en && ctrl_wr_data[0] && ctrl_wr_data[2:1] != 2'd2 |-> !ctrl_wr_data[6]);
  a_r9_clean_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !last_q[0] && !last_q[5] && !last_q[6]);
  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
endmodule

bind adc_seq_top adc_seq_chk #(.GAP_CYC(GAP_CYC), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
  .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .rd_req(rd_req),
  .rd_addr(rd_addr), .rd_ack(rd_ack)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
  localparam int GAP = 50, BIAS = 200, TO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_chan = '0;
  logic req_ready, rsp_valid, ctrl_wr_en, rd_req;
  logic [9:0] rsp_data;
  logic [1:0] rsp_err;
  logic [7:0] ctrl_wr_addr, ctrl_wr_data, rd_addr;
  logic rd_ack = 1'b0, rd_err = 1'b0, conv_done = 1'b0;
  logic [7:0] rd_data = '0;

  always #4 clk = ~clk;

  adc_seq_top #(.CLK_KHZ(1000), .GAP_US(GAP), .BIAS_US(BIAS), .TIMEOUT_US(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .ctrl_wr_en(ctrl_wr_en),
    .ctrl_wr_addr(ctrl_wr_addr), .ctrl_wr_data(ctrl_wr_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .conv_done(conv_done)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  logic clr_logs = 1'b0, stale_kick = 1'b0;
  logic [7:0] mem [8];
  int conv_delay = 0, err_at = 0, conv_cnt = 0;
  logic [7:0] wlog [8];
  int wstamp [8];
  int wn = 0, bad_addr = 0;
  logic [7:0] rlog [4];
  int rn = 0;
  logic [7:0] exp_ctrl = '0;

  // external device models (posedge, nonblocking)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_logs) begin
      wn <= 0; rn <= 0; bad_addr <= 0;
    end else begin
      if (ctrl_wr_en) begin
        if (wn < 8) begin wlog[wn] <= ctrl_wr_data; wstamp[wn] <= cyc; end
        wn <= wn + 1;
        if (ctrl_wr_addr != 8'h50) bad_addr <= bad_addr + 1;
      end
      if (rd_req && !rd_ack) begin
        if (rn < 4) rlog[rn] <= rd_addr;
        rn <= rn + 1;
      end
    end
    rd_ack  <= rd_req && !rd_ack;
    rd_data <= mem[3'(rd_addr - 8'h54)];
    rd_err  <= rd_req && !rd_ack && (err_at == rn + 1);
    if (ctrl_wr_en && ctrl_wr_data[0]) conv_cnt <= conv_delay;
    else if (conv_cnt != 0)            conv_cnt <= conv_cnt - 1;
    conv_done <= (conv_cnt == 1) || stale_kick;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input int ch, input int hi, input int lo, input int dly,
                         input int eat, input int exp_st, input int bp, input bit poke);
    logic [7:0] e [6];
    int n, ien, ist, itd;
    logic [9:0] held;
    @(negedge clk);
    chk(req_ready, "R1 ready when idle", req_ready, 1);
    for (int i = 0; i < 8; i++) mem[i] = 8'(8'h11 * i + 3);
    mem[2*ch] = 8'(hi); mem[2*ch+1] = 8'(lo);
    conv_delay = dly; err_at = eat;
    clr_logs = 1'b1; req_valid = 1'b1; req_chan = 2'(ch);
    @(negedge clk);
    clr_logs = 1'b0; req_valid = 1'b0;
    if (poke) begin
      for (int i = 0; i < 12; i++) begin
        req_valid = 1'b1; req_chan = 2'd3;
        @(negedge clk);
        chk(!req_ready, "R1 busy refuses request", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    // expected control write sequence
    n = 0;
    if (ch == 2) begin e[n] = exp_ctrl | 8'h40; exp_ctrl = e[n]; n++; end
    ien = n; e[n] = exp_ctrl | 8'h20; exp_ctrl = e[n]; n++;
    e[n] = (exp_ctrl & 8'hF9) | 8'(ch << 1); exp_ctrl = e[n]; n++;
    ist = n; e[n] = exp_ctrl | 8'h01; exp_ctrl = e[n]; n++;
    itd = n; e[n] = exp_ctrl & 8'hDE; exp_ctrl = e[n]; n++;
    if (ch == 2) begin e[n] = exp_ctrl & 8'hBF; exp_ctrl = e[n]; n++; end
    chk(wn == n, "R9 write count before response", wn, n);
    chk(bad_addr == 0, "R2 control address 0x50", bad_addr, 0);
    for (int i = 0; i < n && i < wn; i++)
      chk(wlog[i] == e[i], (i == itd || i == itd + 1) ? "R9 teardown write" : "R2 write order",
          wlog[i], e[i]);
    chk(wstamp[ist] - wstamp[ien] == GAP, "R3 enable-to-start gap", wstamp[ist] - wstamp[ien], GAP);
    if (ch == 2) chk(wstamp[ien] - wstamp[0] == BIAS, "R4 bias lead", wstamp[ien] - wstamp[0], BIAS);
    chk(rsp_err == 2'(exp_st), "R6 R7 R8 status", rsp_err, exp_st);
    if (exp_st == 1) begin
      chk(rn == 0, "R6 no reads on timeout", rn, 0);
      chk(wstamp[itd] - wstamp[ist] == TO + 1, "R6 timeout cycle", wstamp[itd] - wstamp[ist], TO + 1);
    end else if (exp_st == 2) begin
      chk(rn == eat, "R8 no read after error", rn, eat);
      chk(rsp_data == 0, "R8 data zero", rsp_data, 0);
    end else begin
      chk(rn == 2, "R7 two reads", rn, 2);
      chk(rlog[0] == 8'(8'h54 + 2*ch), "R7 first address", rlog[0], 8'h54 + 2*ch);
      chk(rlog[1] == 8'(8'h55 + 2*ch), "R7 second address", rlog[1], 8'h55 + 2*ch);
      chk(rsp_data == 10'(((hi << 8) | lo) & 10'h3FF), "R7 result", rsp_data, ((hi << 8) | lo) & 10'h3FF);
    end
    held = rsp_data;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held && rsp_err == 2'(exp_st), "R10 response held", rsp_data, held);
      chk(!req_ready, "R1 busy while response pending", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 response taken", rsp_valid, 0);
  endtask

  typedef struct packed {
    logic [1:0] ch; logic [7:0] hi; logic [7:0] lo;
    logic [7:0] dly; logic [1:0] eat; logic [1:0] st;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 8'hFF, 8'hA5, 8'd5,  2'd0, 2'd0},
    '{2'd1, 8'h02, 8'h00, 8'd20, 2'd0, 2'd0},
    '{2'd2, 8'h01, 8'h7E, 8'd3,  2'd0, 2'd0},
    '{2'd3, 8'hFC, 8'h01, 8'd1,  2'd0, 2'd0},
    '{2'd1, 8'h00, 8'h00, 8'd0,  2'd0, 2'd1},
    '{2'd3, 8'h03, 8'h33, 8'd4,  2'd1, 2'd2},
    '{2'd2, 8'h01, 8'h55, 8'd4,  2'd2, 2'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !ctrl_wr_en && !rd_req, "R11 outputs in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R11 idle after reset", rsp_valid, 0);

    foreach (VECS[i])
      run_req(VECS[i].ch, VECS[i].hi, VECS[i].lo, VECS[i].dly, VECS[i].eat,
              VECS[i].st, 0, 1'b0);

    // busy refusal and response back-pressure
    run_req(0, 8'h01, 8'h23, 10, 0, 0, 6, 1'b1);

    // stale done pulse while idle must not complete the next conversion (R5)
    @(negedge clk); stale_kick = 1'b1;
    @(negedge clk); stale_kick = 1'b0;
    repeat (3) @(negedge clk);
    run_req(0, 8'h02, 8'h22, 0, 0, 1, 0, 1'b0);
    chk(1'b1, "R5 stale pulse ignored (timeout above)", 0, 0);

    // reset in the middle of a thermistor conversion
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd2;
    @(negedge clk); req_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !ctrl_wr_en && !rd_req, "R11 mid-run reset", req_ready, 1);
    rst_n = 1'b1; exp_ctrl = '0;
    repeat (2) @(negedge clk);
    run_req(2, 8'h03, 8'hFF, 6, 0, 0, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule